// File: doc/BRIEF.md
# Multi-Width Pin Pattern Serializer

This block turns a stream of 32-bit words into a timed bit pattern on up to four output pins. Each strobe of the sample clock puts one sample on the pins. A sample is 1, 2 or 4 bits wide, as the lane mode selects, so one word lasts 32, 16 or 8 sample ticks. Samples leave each word from its least significant end. Bit 0 of a sample always drives pin 0, and higher sample bits drive the pins above it. Pins that the mode does not use are driven low.

Software arms a run by giving a word count. A run is always a whole number of words long. The serializer takes a new word from a valid/ready source only at the sample tick that needs it. If no word is offered at that tick, the pins keep their value and a sticky underflow flag is set. Each word carries a buffer-end flag. When the last sample of a flagged word reaches the pins and the event enable is set, a high pulse of a fixed number of clock cycles is produced. That number is a parameter, chosen so the pulse spans at least 148 ns.

Top module: `pat_serializer`

## Requirements
- R1: After reset, pinsOut, busy, evPulse, underflow and wordReady are all 0, and the lane mode is 1-pin (code 0).
- R2: Lane mode code 0 (1 pin) gives 32 samples per word. Sample i is word bit i on pinsOut[0], and pinsOut[3:1] are 0.
- R3: Lane mode code 1 (2 pins) gives 16 samples per word. Sample i is word bits [2i+1:2i] on pinsOut[1:0], the lower bit on pin 0, and pinsOut[3:2] are 0.
- R4: Lane mode code 2 (4 pins) gives 8 samples per word. Sample i is word bits [4i+3:4i] on pinsOut[3:0], the lower bit on pin 0.
- R5: pinsOut changes only in the clock cycle after a cycle with sampleTick high. Without a tick the pins hold their value.
- R6: startRun with a nonzero runLen, while idle, sets busy. wordReady is high only in a cycle with sampleTick, busy, and the current word fully sent. Exactly runLen words are taken. busy falls on the same edge that puts the final sample of the last word on the pins.
- R7: When the final sample of a word whose wordLast was high goes onto the pins, and evEnable is high at that tick, evPulse is high for exactly PULSE_CYCLES cycles, starting at that edge. With evEnable low there is no pulse. The pulse can occur in the middle of a run.
- R8: If wordValid is low at a tick that needs a word, the pins hold and underflow becomes 1. The next tick tries again. underflow stays 1 until the next accepted startRun clears it.
- R9: modeWr loads modeIn only while idle. A write while busy, or of code 3, leaves the mode unchanged.
- R10: startRun is ignored while busy, and it is ignored when runLen is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWr | input | 1 | Lane mode write strobe |
| modeIn | input | 2 | Lane mode code: 0 = 1 pin, 1 = 2 pins, 2 = 4 pins |
| evEnable | input | 1 | Enables the buffer-end event pulse |
| startRun | input | 1 | Starts a run of runLen words |
| runLen | input | CNT_W | Number of words in the run |
| sampleTick | input | 1 | One-cycle strobe that advances one sample |
| wordData | input | WORD_W | Offered word |
| wordLast | input | 1 | Offered word ends a buffer |
| wordValid | input | 1 | A word is offered |
| wordReady | output | 1 | The word is taken in this cycle |
| pinsOut | output | 4 | Pattern pins |
| busy | output | 1 | A run is in progress |
| evPulse | output | 1 | Buffer-end event pulse |
| underflow | output | 1 | Sticky flag: a word was missing when needed |

## Verification
Two functions can meet in one cycle: the buffer-end event and the end of the run. Both fire when the final sample of a word is placed on the pins. The bench provokes this with a one-word run whose word carries the buffer-end flag. At the negedge after the final tick, it requires evPulse high and busy low in the same sample, and then it counts the pulse width. A second case sets the flag on the first word of a two-word run. That case expects the pulse while busy stays high, and no second pulse when the run ends.

// File: rtl/pat_ser_pkg.sv
package pat_ser_pkg;
  typedef enum logic [1:0] {
    LANE1 = 2'b00,
    LANE2 = 2'b01,
    LANE4 = 2'b10
  } laneMode_t;

  typedef struct packed {
    logic load;
    logic shift;
  } serStrobe_t;
endpackage

// File: rtl/pat_ser_ctrl.sv
module pat_ser_ctrl
  import pat_ser_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int CNT_W        = 16,
  parameter int PULSE_CYCLES = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             startRun,
  input  logic [CNT_W-1:0] runLen,
  input  logic             modeWr,
  input  logic [1:0]       modeIn,
  input  logic             evEnable,
  input  logic             wordValid,
  input  logic             wordLast,
  output logic             wordReady,
  output laneMode_t        mode,
  output serStrobe_t       strobe,
  output logic             busy,
  output logic             evPulse,
  output logic             underflow
);
  localparam int SAMP_W  = $clog2(WORD_W + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [SAMP_W-1:0] SPW1 = SAMP_W'(WORD_W);
  localparam logic [SAMP_W-1:0] SPW2 = SAMP_W'(WORD_W / 2);
  localparam logic [SAMP_W-1:0] SPW4 = SAMP_W'(WORD_W / 4);

  logic [SAMP_W-1:0]  samplesLeft;
  logic [CNT_W-1:0]   wordsLeft;
  logic               lastFlag;
  logic [PULSE_W-1:0] pulseCnt;
  logic [SAMP_W-1:0]  spw;
  logic               startAcc, modeAcc, needWord, finalSample;

  always_comb begin
    case (mode)
      LANE2:   spw = SPW2;
      LANE4:   spw = SPW4;
      default: spw = SPW1;
    endcase
  end

  assign startAcc     = startRun && !busy && (runLen != '0);
  assign modeAcc      = modeWr && !busy && (modeIn != 2'b11);
  assign needWord     = busy && (samplesLeft == '0);
  assign wordReady    = sampleTick && needWord;
  assign strobe.load  = wordReady && wordValid;
  assign strobe.shift = sampleTick && busy && (samplesLeft != '0);
  assign finalSample  = strobe.shift && (samplesLeft == SAMP_W'(1));
  assign evPulse      = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= LANE1;
    else if (modeAcc) mode <= laneMode_t'(modeIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      wordsLeft   <= '0;
      samplesLeft <= '0;
      lastFlag    <= 1'b0;
      underflow   <= 1'b0;
    end else if (startAcc) begin
      busy        <= 1'b1;
      wordsLeft   <= runLen;
      samplesLeft <= '0;
      underflow   <= 1'b0;
    end else begin
      if (strobe.load) begin
        samplesLeft <= spw - SAMP_W'(1);
        wordsLeft   <= wordsLeft - CNT_W'(1);
        lastFlag    <= wordLast;
      end
      if (wordReady && !wordValid) underflow <= 1'b1;
      if (strobe.shift) begin
        samplesLeft <= samplesLeft - SAMP_W'(1);
        if (finalSample && (wordsLeft == '0)) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (finalSample && lastFlag && evEnable) pulseCnt <= PULSE_W'(PULSE_CYCLES);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - PULSE_W'(1);
  end

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !startAcc |=> underflow);
  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(mode));
  // R7
  event_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evPulse) |-> $past(evEnable));
  // R6
  run_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(sampleTick));
endmodule

// File: rtl/pat_ser_datapath.sv
module pat_ser_datapath
  import pat_ser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  laneMode_t         mode,
  input  logic [WORD_W-1:0] wordData,
  output logic [3:0]        pinsOut
);
  localparam int N_LANE_MODES = 3;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] srcWord;
  logic [3:0]        lanePins [N_LANE_MODES];
  logic [WORD_W-1:0] laneRest [N_LANE_MODES];
  logic [3:0]        nextPins;
  logic [WORD_W-1:0] nextRest;

  assign srcWord = strobe.load ? wordData : shiftReg;

  for (genvar g = 0; g < N_LANE_MODES; g++) begin : gLane
    localparam int LW = 1 << g;
    assign lanePins[g] = 4'(srcWord[LW-1:0]);
    assign laneRest[g] = srcWord >> LW;
  end

  always_comb begin
    case (mode)
      LANE2:   begin nextPins = lanePins[1]; nextRest = laneRest[1]; end
      LANE4:   begin nextPins = lanePins[2]; nextRest = laneRest[2]; end
      default: begin nextPins = lanePins[0]; nextRest = laneRest[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinsOut  <= '0;
      shiftReg <= '0;
    end else if (strobe.load || strobe.shift) begin
      pinsOut  <= nextPins;
      shiftReg <= nextRest;
    end
  end

  // R2
  one_pin_upper_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.shift) && (mode == LANE1) |=> (pinsOut[3:1] == 3'b000));
  // R3
  two_pin_upper_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.shift) && (mode == LANE2) |=> (pinsOut[3:2] == 2'b00));
endmodule

// File: rtl/pat_serializer.sv
module pat_serializer
  import pat_ser_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int CNT_W        = 16,
  parameter int PULSE_CYCLES = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [1:0]        modeIn,
  input  logic              evEnable,
  input  logic              startRun,
  input  logic [CNT_W-1:0]  runLen,
  input  logic              sampleTick,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordLast,
  input  logic              wordValid,
  output logic              wordReady,
  output logic [3:0]        pinsOut,
  output logic              busy,
  output logic              evPulse,
  output logic              underflow
);
  serStrobe_t strobe;
  laneMode_t  mode;

  pat_ser_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) uCtrl (
    .clk, .rstN, .sampleTick, .startRun, .runLen, .modeWr, .modeIn, .evEnable,
    .wordValid, .wordLast, .wordReady, .mode, .strobe, .busy, .evPulse, .underflow
  );

  pat_ser_datapath #(.WORD_W(WORD_W)) uData (
    .clk, .rstN, .strobe, .mode, .wordData, .pinsOut
  );

  // R5
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(pinsOut));
endmodule

// File: tb/pat_serializer_test.sv
module pat_serializer_test;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWr = 1'b0;
  logic [1:0]  modeIn = 2'b00;
  logic        evEnable = 1'b0;
  logic        startRun = 1'b0;
  logic [15:0] runLen = '0;
  logic        sampleTick = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordLast = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [3:0]  pinsOut;
  logic        busy, evPulse, underflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic lastReady;

  always #5 clk = ~clk;

  pat_serializer #(.WORD_W(32), .CNT_W(16), .PULSE_CYCLES(PULSE)) uut (
    .clk, .rstN, .modeWr, .modeIn, .evEnable, .startRun, .runLen, .sampleTick,
    .wordData, .wordLast, .wordValid, .wordReady, .pinsOut, .busy, .evPulse, .underflow
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] word;
    logic [3:0]  firstPins;
    logic [5:0]  nSamp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 32'hA5A5_0F01, 4'h1, 6'd32},
    '{2'd0, 32'h8000_0000, 4'h0, 6'd32},
    '{2'd1, 32'h1234_5678, 4'h0, 6'd16},
    '{2'd1, 32'hFFFF_FFFE, 4'h2, 6'd16},
    '{2'd2, 32'hDEAD_BEEF, 4'hF, 6'd8},
    '{2'd2, 32'h0000_0007, 4'h7, 6'd8}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setMode(logic [1:0] m);
    @(negedge clk); modeWr = 1'b1; modeIn = m;
    @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic doStart(logic [15:0] n);
    @(negedge clk); startRun = 1'b1; runLen = n;
    @(negedge clk); startRun = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sampleTick = 1'b1;
    #1 lastReady = wordReady;
    @(negedge clk); sampleTick = 1'b0;
  endtask

  task automatic offer(logic [31:0] w, logic last);
    wordData = w; wordLast = last; wordValid = 1'b1;
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (evPulse && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w, mism, plen, taken;
    logic [3:0] expP, held;
    logic [31:0] mask;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", 32'(pinsOut), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 evPulse", 32'(evPulse), 0);
    check("R1 underflow", 32'(underflow), 0);
    check("R1 wordReady", 32'(wordReady), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 vector table
    foreach (VECS[k]) begin
      setMode(VECS[k].mode);
      w = 1 << VECS[k].mode;
      mask = (32'd1 << w) - 1;
      doStart(16'd1);
      offer(VECS[k].word, 1'b0);
      mism = 0;
      for (int i = 0; i < int'(VECS[k].nSamp); i++) begin
        tick();
        wordValid = 1'b0;
        expP = 4'((VECS[k].word >> (i * w)) & mask);
        if (i == 0) check("R2/R3/R4 first sample", 32'(pinsOut), 32'(VECS[k].firstPins));
        if (pinsOut !== expP) begin
          mism++;
          $display("FAIL R%0d sample %0d actual=%0h expected=%0h",
                   VECS[k].mode + 2, i, pinsOut, expP);
        end
      end
      total++; if (mism != 0) bad++;
      check("R6 busy low after run", 32'(busy), 0);
    end

    // R5 pins hold without tick
    held = pinsOut;
    repeat (5) @(negedge clk);
    check("R5 hold idle", 32'(pinsOut), 32'(held));
    setMode(2'd2);
    doStart(16'd1);
    offer(32'h8765_4321, 1'b0);
    tick(); wordValid = 1'b0;
    check("R4 first", 32'(pinsOut), 1);
    repeat (4) @(negedge clk);
    check("R5 hold mid word", 32'(pinsOut), 1);
    check("R6 no ready without tick", 32'(wordReady), 0);
    for (int i = 1; i < 8; i++) tick();
    check("R4 last", 32'(pinsOut), 8);

    // R6 two-word run, R7 event mid-run
    evEnable = 1'b1;
    doStart(16'd2);
    taken = 0;
    offer(32'h1111_1111, 1'b1);
    tick(); if (lastReady) taken++;
    offer(32'h2222_2222, 1'b0);
    for (int i = 1; i < 8; i++) begin tick(); if (lastReady) taken++; end
    check("R7 mid-run pulse", 32'(evPulse), 1);
    check("R6 busy mid run", 32'(busy), 1);
    measurePulse(plen);
    check("R7 pulse width", 32'(plen), PULSE);
    for (int i = 0; i < 8; i++) begin tick(); if (lastReady) taken++; end
    wordValid = 1'b0;
    check("R6 words taken", 32'(taken), 2);
    check("R6 busy drop", 32'(busy), 0);
    check("R7 no pulse unflagged", 32'(evPulse), 0);

    // R7 event and run end in same cycle
    doStart(16'd1);
    offer(32'hF0F0_F0F0, 1'b1);
    for (int i = 0; i < 8; i++) begin tick(); wordValid = 1'b0; end
    check("R7 pulse at run end", 32'(evPulse), 1);
    check("R6 busy low with pulse", 32'(busy), 0);
    measurePulse(plen);
    check("R7 pulse width at end", 32'(plen), PULSE);

    // R7 disabled
    evEnable = 1'b0;
    doStart(16'd1);
    offer(32'h0F0F_0F0F, 1'b1);
    for (int i = 0; i < 8; i++) begin tick(); wordValid = 1'b0; end
    @(negedge clk);
    check("R7 disabled no pulse", 32'(evPulse), 0);

    // R8 underflow
    setMode(2'd0);
    held = pinsOut;
    doStart(16'd1);
    wordValid = 1'b0;
    tick();
    check("R8 ready asked", 32'(lastReady), 1);
    check("R8 pins hold", 32'(pinsOut), 32'(held));
    check("R8 flag set", 32'(underflow), 1);
    offer(32'h0000_0003, 1'b0);
    tick(); wordValid = 1'b0;
    check("R8 retry loads", 32'(pinsOut), 1);
    check("R8 sticky", 32'(underflow), 1);
    for (int i = 1; i < 32; i++) tick();
    check("R8 sticky after run", 32'(underflow), 1);
    doStart(16'd1);
    check("R8 cleared by start", 32'(underflow), 0);
    offer(32'h0000_0000, 1'b0);
    for (int i = 0; i < 32; i++) begin tick(); wordValid = 1'b0; end

    // R9 mode write while busy ignored
    doStart(16'd1);
    setMode(2'd2);
    offer(32'hFFFF_FFFF, 1'b0);
    tick(); wordValid = 1'b0;
    check("R9 busy write ignored", 32'(pinsOut), 1);
    for (int i = 1; i < 32; i++) tick();
    check("R9 still 1-pin length", 32'(busy), 0);
    setMode(2'd3);
    doStart(16'd1);
    offer(32'hFFFF_FFFF, 1'b0);
    tick(); wordValid = 1'b0;
    check("R9 code 3 ignored", 32'(pinsOut), 1);
    for (int i = 1; i < 32; i++) tick();
    setMode(2'd1);
    doStart(16'd1);
    offer(32'h0000_0003, 1'b0);
    tick(); wordValid = 1'b0;
    check("R9 idle write taken", 32'(pinsOut), 3);
    for (int i = 1; i < 16; i++) tick();
    check("R3 run length", 32'(busy), 0);

    // R10 start ignored
    doStart(16'd0);
    check("R10 zero length", 32'(busy), 0);
    setMode(2'd2);
    doStart(16'd1);
    doStart(16'd5);
    offer(32'h5555_5555, 1'b0);
    for (int i = 0; i < 8; i++) begin tick(); wordValid = 1'b0; end
    check("R10 restart ignored", 32'(busy), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule